// File: doc/BRIEF.md
# Modem Line Status and Control Tracker

This block holds the modem-side registers of a byte-wide serial controller. Four incoming handshake lines are sampled: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer chain. The block keeps the current level of each line and a set of sticky change flags. A change flag stays set until software reads the status register. An interrupt request is raised when the change flags are non-zero and the external modem-interrupt enable is high.

A five-bit control register drives four handshake outputs: ready-to-send, terminal-ready and two general outputs. Bit 4 of that register selects an internal loopback test mode. In loopback the outputs are forced inactive, and a status read reports the control bits in place of the real lines. The register interface has a one-bit register select and separate read and write strobes. Read data is combinational, and the read side effect takes place at the clock edge where the read strobe is high.

Top module: `modem_line_monitor`

## Requirements
- R1: After reset the control register reads 0x08. Only out2_o is asserted, irq_o is low, and the status register reads 0xB0: carrier, data-set-ready and clear-to-send high, ring low, all change flags clear.
- R2: The status byte places the line levels at carrier bit 7, ring bit 6, data-set-ready bit 5 and clear-to-send bit 4. A change on an input is reflected SYNC_STAGES+1 clock edges later.
- R3: Change flags for carrier (bit 3), data-set-ready (bit 1) and clear-to-send (bit 0) are set by a transition in either direction. Once set they stay set until a clearing status read.
- R4: The ring change flag (bit 2) is set only when the ring line falls from 1 to 0. A rising ring line leaves it clear.
- R5: A status read with loopback off returns the current byte and then clears bits 3:0. A line change recorded on the same clock edge as the clearing read survives that read.
- R6: A control write keeps wdata bits 4:0: terminal-ready bit 0, ready-to-send bit 1, out1 bit 2, out2 bit 3, loopback bit 4. The register reads back with the upper bits zero. With loopback off, each stored bit drives its output pin.
- R7: With loopback on, all four output pins are low. A status read returns out2 in bit 7, out1 in bit 6, terminal-ready in bit 5, ready-to-send in bit 4 and zero in bits 3:0, and it leaves the change flags unchanged.
- R8: irq_o is high exactly when msi_en is high and any change flag is set.
- R9: A write with the status register selected changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a status read clears the change flags at the clock edge |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| rts_o | output | 1 | Ready-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench drives all 256 ordered pairs of line states. For each pair it compares the change flags against an XOR model that treats ring as a special case. A design that flags rising ring edges, or that drops flags between reads, fails the sweep. A line change is timed to land on the same edge as a clearing read; a design that lets the clear win loses that event. The bench also writes every control value and reads every loopback mapping. Any remapping mistake shows up in the read data. A loopback read that clears the flags shows up once loopback is turned off again.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
   localparam int unsigned LINE_N = 4;
   localparam int unsigned CTRL_W = 5;

   // line index inside the level / change nibble
   localparam int unsigned L_CTS = 0;
   localparam int unsigned L_DSR = 1;
   localparam int unsigned L_RI  = 2;
   localparam int unsigned L_DCD = 3;

   // control register bit positions
   localparam int unsigned C_DTR  = 0;
   localparam int unsigned C_RTS  = 1;
   localparam int unsigned C_OUT1 = 2;
   localparam int unsigned C_OUT2 = 3;
   localparam int unsigned C_LOOP = 4;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   // level nibble seen by software while the loopback path is active
   function automatic logic [LINE_N-1:0] loop_levels(input logic [CTRL_W-1:0] c);
      logic [LINE_N-1:0] v;
      v[L_DCD] = c[C_OUT2];
      v[L_RI]  = c[C_OUT1];
      v[L_DSR] = c[C_DTR];
      v[L_CTS] = c[C_RTS];
      return v;
   endfunction
endpackage

// File: rtl/mlm_sync.sv
module mlm_sync #(
   parameter int unsigned N       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][N-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mlm_delta.sv
module mlm_delta
   import mlm_pkg::*;
#(
   parameter logic [LINE_N-1:0] RST_LEVEL = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_N-1:0] lvl_in,
   input  logic              rd_clr,
   output logic [LINE_N-1:0] level_q,
   output logic [LINE_N-1:0] delta_q
);
   logic [LINE_N-1:0] chg;
   logic [LINE_N-1:0] delta_n;

   // per-line change detection; ring only counts a falling edge
   generate
      for (genvar g = 0; g < int'(LINE_N); g++) begin : g_line
         if (g == int'(L_RI)) begin : g_fall
            assign chg[g] = level_q[g] & ~lvl_in[g];
         end else begin : g_any
            assign chg[g] = level_q[g] ^ lvl_in[g];
         end
      end
   endgenerate

   always_comb begin
      delta_n = (rd_clr ? '0 : delta_q) | chg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= RST_LEVEL;
         delta_q <= '0;
      end else begin
         level_q <= lvl_in;
         delta_q <= delta_n;
      end
   end

   // R3: without a clearing read, no flag ever drops
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

   // R4: ring flag rises only with a 1->0 ring level step
   p_ring_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delta_q[L_RI]) |-> ($past(level_q[L_RI]) && !level_q[L_RI]));

   // R5: after a clearing read only freshly detected changes remain
   p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((delta_q & ~$past(chg)) == '0));
endmodule

// File: rtl/mlm_ctrl.sv
module mlm_ctrl
   import mlm_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RST_VAL = 5'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              rts,
   output logic              dtr,
   output logic              out1,
   output logic              out2
);
   logic drive_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= RST_VAL;
      else if (wr) ctrl_q <= wdata;
   end

   assign drive_en = ~ctrl_q[C_LOOP];
   assign rts  = drive_en & ctrl_q[C_RTS];
   assign dtr  = drive_en & ctrl_q[C_DTR];
   assign out1 = drive_en & ctrl_q[C_OUT1];
   assign out2 = drive_en & ctrl_q[C_OUT2];

   // R6: register only moves on a write
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor
   import mlm_pkg::*;
#(
   parameter int unsigned        DATA_W      = 8,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [CTRL_W-1:0]  CTRL_RESET  = 5'h08,
   parameter logic [LINE_N-1:0]  LEVEL_RESET = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              msi_en,
   input  logic              cts_i,
   input  logic              dsr_i,
   input  logic              ri_i,
   input  logic              dcd_i,
   output logic              rts_o,
   output logic              dtr_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              irq_o
);
   localparam int unsigned STAT_W = 2 * LINE_N;

   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("DATA_W must hold the full status byte");
      end
      if (SYNC_STAGES > 6) begin : g_bad_sync
         $error("SYNC_STAGES larger than supported");
      end
   endgenerate

   logic [LINE_N-1:0] raw_lines, sync_lines, level_q, delta_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              loop_on, stat_sel, rd_clr, ctrl_wr;
   logic [STAT_W-1:0] stat_byte;

   assign raw_lines[L_CTS] = cts_i;
   assign raw_lines[L_DSR] = dsr_i;
   assign raw_lines[L_RI]  = ri_i;
   assign raw_lines[L_DCD] = dcd_i;

   assign stat_sel = (reg_sel_e'(reg_sel) == SEL_STAT);
   assign loop_on  = ctrl_q[C_LOOP];
   assign rd_clr   = rd_en & stat_sel & ~loop_on;
   assign ctrl_wr  = wr_en & ~stat_sel;

   mlm_sync #(
      .N       (LINE_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (LEVEL_RESET)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (sync_lines)
   );

   mlm_delta #(
      .RST_LEVEL (LEVEL_RESET)
   ) u_delta (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_in  (sync_lines),
      .rd_clr  (rd_clr),
      .level_q (level_q),
      .delta_q (delta_q)
   );

   mlm_ctrl #(
      .RST_VAL (CTRL_RESET)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctrl_wr),
      .wdata  (wdata[CTRL_W-1:0]),
      .ctrl_q (ctrl_q),
      .rts    (rts_o),
      .dtr    (dtr_o),
      .out1   (out1_o),
      .out2   (out2_o)
   );

   always_comb begin
      if (loop_on) stat_byte = {loop_levels(ctrl_q), {LINE_N{1'b0}}};
      else         stat_byte = {level_q, delta_q};
   end

   always_comb begin
      rdata = '0;
      if (stat_sel) rdata[STAT_W-1:0] = stat_byte;
      else          rdata[CTRL_W-1:0] = ctrl_q;
   end

   assign irq_o = msi_en & (|delta_q);

   // R8: no request while the enable is low
   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en |-> !irq_o);

   // R7: loopback silences every output pin
   p_loop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |-> !(rts_o || dtr_o || out1_o || out2_o));

   // R9: status-selected writes leave the control register alone
   p_stat_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && stat_sel) |=> $stable(ctrl_q));

   // R6: control readback never shows bits above the stored field
   p_ctrl_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_sel |-> (rdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: tb/modem_line_monitor_tb.sv
`timescale 1ns/1ps
module modem_line_monitor_tb;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, msi_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
   logic       rts_o, dtr_o, out1_o, out2_o, irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   modem_line_monitor #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
      .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
      .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o), .irq_o(irq_o));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // v: bit3 carrier, bit2 ring, bit1 data-set-ready, bit0 clear-to-send
   task automatic set_lines(input logic [3:0] v);
      @(negedge clk);
      dcd_i = v[3]; ri_i = v[2]; dsr_i = v[1]; cts_i = v[0];
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(posedge clk);
   endtask

   task automatic bus_read(input logic sel, output logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; rd_en = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic bus_write(input logic sel, input logic [7:0] v);
      @(negedge clk);
      reg_sel = sel; wdata = v; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] d2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      reg_sel = 1'b1; #1 check("R1 status", rdata, 8'hB0);
      reg_sel = 1'b0; #1 check("R1 control", rdata, 8'h08);
      check("R1 pins", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
      check("R1 irq", {7'h0, irq_o}, 8'h00);

      // R2 R3 R4 R8 all ordered pairs of line states
      msi_en = 1'b1;
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic [3:0] av, bv, dv;
            av = a[3:0]; bv = b[3:0];
            set_lines(av); settle();
            bus_read(1'b1, d);
            set_lines(bv); settle();
            dv = av ^ bv;
            dv[2] = av[2] & ~bv[2];
            @(negedge clk);
            check("R8 irq with flags", {7'h0, irq_o}, {7'h0, |dv});
            bus_read(1'b1, d);
            check("R2 R3 R4 status after step", d, {bv, dv});
         end
      end

      // R8 enable low masks request
      set_lines(4'b1011); settle(); bus_read(1'b1, d);
      set_lines(4'b1010); settle();
      @(negedge clk);
      msi_en = 1'b0; #1 check("R8 masked", {7'h0, irq_o}, 8'h00);
      msi_en = 1'b1; #1 check("R8 enabled", {7'h0, irq_o}, 8'h01);
      // R3 flag sticks across idle cycles
      repeat (10) @(posedge clk);
      bus_read(1'b1, d); check("R3 sticky until read", d, 8'hA1);
      bus_read(1'b1, d); check("R5 cleared by read", d, 8'hA0);

      // R5 change landing on the clearing edge survives
      set_lines(4'b1011);
      repeat (SYNC) @(posedge clk);
      bus_read(1'b1, d);
      check("R5 read before change", d, 8'hA0);
      bus_read(1'b1, d);
      check("R5 coincident change kept", d, 8'hB1);

      // R6 R7 every control value
      for (int w = 0; w < 256; w++) begin
         logic [7:0] wv;
         wv = w[7:0];
         bus_write(1'b0, wv);
         bus_read(1'b0, d);
         check("R6 control readback", d, wv & 8'h1F);
         @(negedge clk);
         check("R6 R7 pins", {4'h0, out2_o, out1_o, rts_o, dtr_o},
               wv[4] ? 8'h00 : {4'h0, wv[3:0]});
         if (wv[4]) begin
            bus_read(1'b1, d);
            check("R7 loopback status", d, {wv[3], wv[2], wv[0], wv[1], 4'h0});
         end
      end

      // R7 loopback read leaves flags intact
      bus_write(1'b0, 8'h08);
      bus_read(1'b1, d);
      set_lines(4'b1010); settle();
      bus_write(1'b0, 8'h1B);
      bus_read(1'b1, d);  check("R7 loop map", d, 8'hB0);
      bus_read(1'b1, d2); check("R7 loop map again", d2, 8'hB0);
      @(negedge clk);
      check("R7 R8 flag still pending", {7'h0, irq_o}, 8'h01);
      bus_write(1'b0, 8'h08);
      bus_read(1'b1, d); check("R7 flags survived loopback", d, 8'hA1);

      // R9 status writes ignored
      set_lines(4'b1011); settle(); bus_read(1'b1, d);
      bus_write(1'b1, 8'hFF);
      bus_read(1'b1, d);  check("R9 status unchanged", d, 8'hB0);
      bus_read(1'b0, d);  check("R9 control unchanged", d, 8'h08);

      summary();
   end
endmodule